// File: doc/BRIEF.md
# Legacy Interrupt Status Controller

This block gathers interrupt events for a PCIe root port and presents them to the processor on two wires. Single-cycle event strobes for the four legacy INTx lines (A to D) are held in a sticky pulse status register. A separate level-type status bit follows the MSI pending input. Each kind of source has its own enable register. `irq_intx` is raised while any pending INTx bit is also enabled. `irq_msi` is raised while the MSI level bit and its enable are both set.

Software reaches the registers over a plain register bus with a 12-bit byte address and 32-bit data. A write takes effect at the clock edge where `reg_wen` is high. Read data is combinational from `reg_addr`. The interrupt service routine reads the pulse status word and writes the same value back, and each 1 it writes clears that bit. Only even bit positions carry INTx sources. Two further slots, one for special status and one for special enable, are reserved and hold nothing.

Top module: `intx_status_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register is cleared. After that edge all register reads return 0 and `irq_intx` and `irq_msi` are low.
- R2: An `intx_evt[i]` high at a clock edge sets bit 2*i of the pulse status word at 0x000. This gives INTA on bit 0, INTB on bit 2, INTC on bit 4 and INTD on bit 6. The bit is set at that edge whatever the enable state.
- R3: A set pulse status bit stays set across any number of cycles, including while its enable is low, until it is cleared by a write.
- R4: A write to 0x000 clears each status bit at an even position 0, 2, 4 or 6 where the written data has a 1. Bits written 0 keep their value. Odd data bits have no effect.
- R5: When an event and a clearing write reach the same status bit at the same edge, the bit ends up set.
- R6: The pulse enable word at 0x00C stores data bits 0, 2, 4 and 6 and reads them back; writing 0x55 enables all four lines. All other bits read 0, so writing 0xFFFFFFFF reads back as 0x55.
- R7: `irq_intx` is high exactly when some pulse status bit and the enable bit at the same position are both 1. It follows a register change in the same cycle.
- R8: The level status word at 0x004 shows at bit 2 the value `msi_level` had at the previous clock edge. Its other bits read 0, and writes to 0x004 change nothing.
- R9: The level enable word at 0x010 stores and returns data bit 2 only. `irq_msi` is high exactly when level status bit 2 and level enable bit 2 are both 1.
- R10: Reads of 0x008, of 0x014, of any misaligned address and of any address not listed above return 0. Writes to those addresses leave every register unchanged.
- R11: `reg_rdata` follows `reg_addr` within the same cycle, and reading has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wen | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| intx_evt | input | 4 | Event strobes for INTA..INTD, bit 0 = INTA |
| msi_level | input | 1 | MSI pending level |
| irq_intx | output | 1 | Combined enabled INTx interrupt |
| irq_msi | output | 1 | Enabled MSI interrupt |

## Verification
The properties assume that `rst_n` is driven low from time zero and that the inputs change only away from the rising clock edge. They also assume that a write address counts only when it matches a slot exactly. The bench drives every input and samples every output two nanoseconds after a rising edge. It holds reset for several edges before any traffic, and it deliberately sends events and clearing writes to the same bits at the same edge. All 16 × 16 combinations of event pattern and enable pattern are swept, so the combined output is checked against every mask.

// File: rtl/intx_status_pkg.sv
// Shared constants and types for the legacy interrupt status controller.
// Assumes a byte-addressed 12-bit register space with word-aligned slots.
package intx_status_pkg;

    localparam int PKG_ADDR_W = 12;

    // Register slot offsets; software depends on these exact values
    localparam logic [PKG_ADDR_W-1:0] OFS_PULSE_STAT = 12'h000;
    localparam logic [PKG_ADDR_W-1:0] OFS_LEVEL_STAT = 12'h004;
    localparam logic [PKG_ADDR_W-1:0] OFS_SPEC_STAT  = 12'h008;
    localparam logic [PKG_ADDR_W-1:0] OFS_PULSE_EN   = 12'h00C;
    localparam logic [PKG_ADDR_W-1:0] OFS_LEVEL_EN   = 12'h010;
    localparam logic [PKG_ADDR_W-1:0] OFS_SPEC_EN    = 12'h014;

    // Decoded register slot
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PSTAT,
        SEL_LSTAT,
        SEL_SSTAT,
        SEL_PEN,
        SEL_LEN,
        SEL_SEN
    } reg_sel_e;

endpackage

// File: rtl/intx_addr_decode.sv
// Address decoder: maps a byte address onto one register slot.
// Assumes exact-match decoding; misaligned or unlisted addresses give SEL_NONE.
module intx_addr_decode
    import intx_status_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);

    // Compare the full address against every slot offset
    always_comb begin
        sel = SEL_NONE;
        if      (addr == ADDR_W'(OFS_PULSE_STAT)) sel = SEL_PSTAT;
        else if (addr == ADDR_W'(OFS_LEVEL_STAT)) sel = SEL_LSTAT;
        else if (addr == ADDR_W'(OFS_SPEC_STAT))  sel = SEL_SSTAT;
        else if (addr == ADDR_W'(OFS_PULSE_EN))   sel = SEL_PEN;
        else if (addr == ADDR_W'(OFS_LEVEL_EN))   sel = SEL_LEN;
        else if (addr == ADDR_W'(OFS_SPEC_EN))    sel = SEL_SEN;
    end

endmodule

// File: rtl/intx_pulse_status.sv
// Sticky pulse status bits with write-one-to-clear.
// Assumes events are one-cycle strobes; a set and a clear on the same
// edge leave the bit set.
module intx_pulse_status #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] stat
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic bit_q;

        // Hold, set on event, clear on written one; set has priority
        always_ff @(posedge clk) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (evt[i])
                bit_q <= 1'b1;
            else if (clr_we && clr_bits[i])
                bit_q <= 1'b0;
        end

        assign stat[i] = bit_q;
    end

endmodule

// File: rtl/intx_enable_reg.sv
// Plain read/write enable register of parameterised width.
// Assumes the caller has already picked out the implemented data bits.
module intx_enable_reg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Load on write strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= d;
    end

endmodule

// File: rtl/intx_status_ctrl.sv
// Legacy interrupt status controller top.
// Sticky INTx pulse status on even bits, a sampled MSI level status bit,
// separate enables, and two interrupt outputs.
// Assumes writes are single-cycle strobes and reads are side-effect free.
module intx_status_ctrl
    import intx_status_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_INTX = 4,
    parameter int MSI_BIT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_INTX-1:0] intx_evt,
    input  logic              msi_level,
    output logic              irq_intx,
    output logic              irq_msi
);

    localparam int LANE_SPAN = 2 * NUM_INTX;

    if (LANE_SPAN > DATA_W || MSI_BIT >= DATA_W) begin : g_bad_cfg
        initial $error("intx_status_ctrl: source bits do not fit in data word");
    end

    reg_sel_e            sel;
    logic [NUM_INTX-1:0] wd_even;
    logic [NUM_INTX-1:0] pstat_q;
    logic [NUM_INTX-1:0] pen_q;
    logic                lstat_q;
    logic                len_q;
    logic [DATA_W-1:0]   pstat_wide;
    logic [DATA_W-1:0]   pen_wide;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata;

    intx_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .sel  (sel)
    );

    // Gather even data bits into compact source order and spread back for reads
    always_comb begin
        pstat_wide = '0;
        pen_wide   = '0;
        for (int i = 0; i < NUM_INTX; i++) begin
            wd_even[i]       = reg_wdata[2*i];
            pstat_wide[2*i]  = pstat_q[i];
            pen_wide[2*i]    = pen_q[i];
        end
    end

    intx_pulse_status #(.NUM_SRC(NUM_INTX)) u_pstat (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (intx_evt),
        .clr_we   (reg_wen && sel == SEL_PSTAT),
        .clr_bits (wd_even),
        .stat     (pstat_q)
    );

    intx_enable_reg #(.WIDTH(NUM_INTX)) u_pen (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_wen && sel == SEL_PEN),
        .d     (wd_even),
        .q     (pen_q)
    );

    intx_enable_reg #(.WIDTH(1)) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_wen && sel == SEL_LEN),
        .d     (reg_wdata[MSI_BIT]),
        .q     (len_q)
    );

    // Sample the MSI pending level once per clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            lstat_q <= 1'b0;
        else
            lstat_q <= msi_level;
    end

    // Read multiplexer; reserved and unmapped slots return zero
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_PSTAT: reg_rdata = pstat_wide;
            SEL_LSTAT: reg_rdata[MSI_BIT] = lstat_q;
            SEL_PEN:   reg_rdata = pen_wide;
            SEL_LEN:   reg_rdata[MSI_BIT] = len_q;
            default:   reg_rdata = '0;
        endcase
    end

    // Interrupt outputs from masked status
    assign irq_intx = |(pstat_q & pen_q);
    assign irq_msi  = lstat_q & len_q;

endmodule

// File: rtl/intx_status_ctrl_sva.sv
// Property checker for intx_status_ctrl, attached by bind below.
// Assumes rst_n is low at the first clock edge.
module intx_status_ctrl_sva
    import intx_status_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int NUM_INTX = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wen,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [NUM_INTX-1:0] intx_evt,
    input logic                msi_level,
    input logic [NUM_INTX-1:0] pstat,
    input logic [NUM_INTX-1:0] pen,
    input logic                lstat,
    input logic                len
);

    logic [NUM_INTX-1:0] wd_even;
    logic                unused_wd;
    logic                wr_pstat, wr_pen, wr_len;

    always_comb begin
        for (int i = 0; i < NUM_INTX; i++) wd_even[i] = reg_wdata[2*i];
    end
    assign unused_wd = ^reg_wdata;
    assign wr_pstat  = reg_wen && reg_addr == ADDR_W'(OFS_PULSE_STAT);
    assign wr_pen    = reg_wen && reg_addr == ADDR_W'(OFS_PULSE_EN);
    assign wr_len    = reg_wen && reg_addr == ADDR_W'(OFS_LEVEL_EN);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pstat == '0 && pen == '0 && !lstat && !len));

    // Also covers R5: set wins over a clear at the same edge
    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (intx_evt != '0) |=> ((pstat & $past(intx_evt)) == $past(intx_evt)));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pstat |=> ((pstat & $past(pstat)) == $past(pstat)));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pstat && intx_evt == '0) |=> (pstat == $past(pstat & ~wd_even)));

    assert_pen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pen |=> $stable(pen));

    assert_level_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lstat == $past(msi_level)));

    assert_len_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_len |=> $stable(len));

endmodule

bind intx_status_ctrl intx_status_ctrl_sva #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_INTX (NUM_INTX)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .intx_evt  (intx_evt),
    .msi_level (msi_level),
    .pstat     (pstat_q),
    .pen       (pen_q),
    .lstat     (lstat_q),
    .len       (len_q)
);

// File: tb/intx_status_ctrl_test.sv
// Self-checking bench: sweeps event and enable patterns and register accesses.
module intx_status_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] addr;
    logic        wen;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [3:0]  evt;
    logic        msi_level;
    logic        irq_intx;
    logic        irq_msi;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam logic [11:0] A_PSTAT = 12'h000;
    localparam logic [11:0] A_LSTAT = 12'h004;
    localparam logic [11:0] A_SSTAT = 12'h008;
    localparam logic [11:0] A_PEN   = 12'h00C;
    localparam logic [11:0] A_LEN   = 12'h010;
    localparam logic [11:0] A_SEN   = 12'h014;

    always #10 clk = ~clk;

    intx_status_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (addr),
        .reg_wen   (wen),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .intx_evt  (evt),
        .msi_level (msi_level),
        .irq_intx  (irq_intx),
        .irq_msi   (irq_msi)
    );

    // Source i lands on bit 2*i
    function automatic logic [31:0] spread(input logic [3:0] v);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++) r[2*i] = v[i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wen = 1'b1;
        tick();
        wen = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    task automatic pulse(input logic [3:0] v);
        evt = v;
        tick();
        evt = '0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; wen = 1'b0; wdata = '0; evt = '0; msi_level = 1'b0;
        repeat (3) tick();
        // R1: reset state
        rd(A_PSTAT, 0, "R1 pstat"); rd(A_LSTAT, 0, "R1 lstat");
        rd(A_PEN, 0, "R1 pen");     rd(A_LEN, 0, "R1 len");
        check("R1 irq_intx", 32'(irq_intx), 0);
        check("R1 irq_msi", 32'(irq_msi), 0);
        rst_n = 1'b1;
        tick();

        // R2, R6, R7: all event x enable combinations
        for (int en = 0; en < 16; en++) begin
            wr(A_PEN, spread(4'(en)));
            rd(A_PEN, spread(4'(en)), "R6 readback");
            for (int ev = 0; ev < 16; ev++) begin
                wr(A_PSTAT, 32'hFF);
                pulse(4'(ev));
                rd(A_PSTAT, spread(4'(ev)), "R2 capture");
                check("R7 irq_intx", 32'(irq_intx), 32'((ev & en) != 0));
            end
        end

        // R6: unimplemented enable bits
        wr(A_PEN, 32'hFFFF_FFFF); rd(A_PEN, 32'h55, "R6 all ones");
        wr(A_PEN, 32'h0000_00AA); rd(A_PEN, 32'h0, "R6 odd bits");
        wr(A_PEN, 32'h0000_0055); rd(A_PEN, 32'h55, "R6 enable all");

        // R4: write-one-to-clear sweep
        for (int m = 0; m < 16; m++) begin
            wr(A_PSTAT, 32'hFF);
            pulse(4'hF);
            wr(A_PSTAT, spread(4'(m)));
            rd(A_PSTAT, spread(4'(~m)), "R4 partial clear");
        end
        pulse(4'hF);
        wr(A_PSTAT, 32'hFFFF_FFAA);
        rd(A_PSTAT, 32'h55, "R4 odd bits no clear");

        // R5: set and clear at the same edge
        evt = 4'b0101;
        wr(A_PSTAT, 32'hFF);
        evt = '0;
        rd(A_PSTAT, spread(4'b0101), "R5 set wins");
        wr(A_PSTAT, 32'hFF);

        // R3: sticky with enable low, then enable
        wr(A_PEN, 32'h0);
        pulse(4'b1000);
        repeat (6) tick();
        rd(A_PSTAT, 32'h40, "R3 sticky");
        check("R3 irq masked", 32'(irq_intx), 0);
        wr(A_PEN, 32'h40);
        check("R7 irq after enable", 32'(irq_intx), 1);
        wr(A_PSTAT, 32'h40);
        check("R7 irq after clear", 32'(irq_intx), 0);

        // R8, R9: MSI level and enable combinations
        for (int le = 0; le < 2; le++) begin
            for (int lv = 0; lv < 2; lv++) begin
                wr(A_LEN, 32'(le) << 2);
                msi_level = 1'(lv);
                rd(A_LSTAT, 32'(1 - lv) << 2 & 32'h0, "R8 not yet sampled");
                tick();
                rd(A_LSTAT, 32'(lv) << 2, "R8 level status");
                rd(A_LEN, 32'(le) << 2, "R9 readback");
                check("R9 irq_msi", 32'(irq_msi), 32'(le & lv));
                msi_level = 1'b0;
                tick();
                rd(A_LSTAT, 0, "R8 follows low");
            end
        end
        wr(A_LSTAT, 32'hFFFF_FFFF);
        rd(A_LSTAT, 0, "R8 write ignored");
        wr(A_LEN, 32'hFFFF_FFFB);
        rd(A_LEN, 0, "R9 other bits");

        // R10: reserved and unmapped addresses
        wr(A_PEN, 32'h55);
        wr(A_LEN, 32'h4);
        pulse(4'b0110);
        foreach (int_addrs[k]) ;
        begin
            logic [11:0] probe [7] = '{A_SSTAT, A_SEN, 12'h018, 12'h001, 12'h00D, 12'h100, 12'hFFC};
            for (int k = 0; k < 7; k++) begin
                wr(probe[k], 32'hFFFF_FFFF);
                rd(probe[k], 0, "R10 reads zero");
                rd(A_PSTAT, spread(4'b0110), "R10 pstat kept");
                rd(A_PEN, 32'h55, "R10 pen kept");
                rd(A_LEN, 32'h4, "R10 len kept");
            end
        end

        // R11: combinational read, no side effect
        rd(A_PSTAT, spread(4'b0110), "R11 first read");
        rd(A_PEN, 32'h55, "R11 same-cycle address change");
        tick();
        rd(A_PSTAT, spread(4'b0110), "R11 repeat read");
        check("R11 irq kept", 32'(irq_intx), 1);

        // R1: mid-run reset
        rst_n = 1'b0;
        tick();
        rd(A_PSTAT, 0, "R1 pstat after reset");
        rd(A_PEN, 0, "R1 pen after reset");
        rd(A_LEN, 0, "R1 len after reset");
        check("R1 irq_intx after reset", 32'(irq_intx), 0);
        check("R1 irq_msi after reset", 32'(irq_msi), 0);
        rst_n = 1'b1;
        tick();

        done = 1;
        summary();
        $finish;
    end

    logic int_addrs [1];

endmodule